// File: doc/BRIEF.md
# SDLC Character Transmit Serializer

This block turns parallel characters into a serial bit stream for a synchronous bit-oriented link. Each pulse of a bit-clock enable puts the next bit on the line, least significant bit first. A character comes in as a byte over a valid/ready handshake, together with a configuration. The configuration sets the character length, whether a parity bit is added, the parity sense and the idle behaviour. The block fills the line itself when no character is waiting. It does this with whole units of eight bits, either the 0x7E flag or eight ones. Which unit it uses is chosen by the idle-mode input.

Framing above the character level is left to the user. Address and control octets are written as ordinary data, and the first byte supplied after idle is the frame's address. The configuration is captured when a unit enters the shift register. The host may therefore change it for the next character while the current one is still leaving.

Top module: `sdlc_tx_serializer`

## Requirements
- R1: While reset is held and until the first enabled bit period ends, `txd` is 1, `busy` is 0 and `tx_ready` is 1.
- R2: The line changes only at a clock edge where `bit_en` is 1, and each such edge advances exactly one bit; every unit is sent least significant bit first.
- R3: Length codes 2'b01, 2'b10 and 2'b11 send the 6, 7 or 8 low bits of `tx_data`, and the bits above the chosen length have no effect on the line.
- R4: Length code 2'b00 sends a variable length. Count the ones from bit 7 downward, stopping at the first zero, and cap the count at 4. The number of bits sent is 5 minus that count, taken from the lowest bits, so 0xF1 and 0xFF both send one bit and 0x15 sends five.
- R5: With `par_en` = 1, one extra bit follows the data bits. With `par_odd` = 0 the data bits plus this bit hold an even number of ones; with `par_odd` = 1 they hold an odd number.
- R6: `tx_ready` is 1 exactly during the last bit period of the unit on the line. A character is taken at an edge where `bit_en`, `tx_valid` and `tx_ready` are all 1, and its first bit follows immediately with no gap.
- R7: When no character is taken at a unit boundary, an eight-bit idle unit is sent: 0x7E with `idle_flag` = 1, eight ones with `idle_flag` = 0.
- R8: Length code, parity settings and idle mode are captured only when a unit is loaded. Changing them while a unit is being sent does not alter that unit, so a switch of idle mode takes effect only after the current group of eight.
- R9: `busy` is 1 exactly during the bit periods of a data character, including its parity bit, and 0 during idle units.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable, one pulse per transmitted bit |
| tx_data | input | 8 | Character byte |
| tx_valid | input | 1 | Character byte is offered |
| tx_ready | output | 1 | Last bit period of current unit; a character is taken at its end |
| len_code | input | 2 | Character length select (00 variable 1..5, 01 six, 10 seven, 11 eight) |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| idle_flag | input | 1 | Idle unit: 1 flag 0x7E, 0 eight ones |
| txd | output | 1 | Serial data line |
| busy | output | 1 | A data character is on the line |

## Verification
The bench builds the block with its default parameters. These give an eight-bit character path, a five-bit minimum length with a four-one marker cap, and the reduction-tree parity variant. With these values every length code is reachable, including all five marker depths of the variable mode. The 0xFF marker saturation case is also reachable, as are both idle patterns and a nine-bit unit with parity on an eight-bit character. Characters are offered back to back while the configuration is changed under a unit in flight. The idle mode is also switched in the middle of a group, which exercises the load-time capture.

// File: rtl/sdlc_ser_pkg.sv
package sdlc_ser_pkg;
   typedef enum logic {
      UNIT_IDLE = 1'b0,
      UNIT_DATA = 1'b1
   } unit_e;

   localparam logic [1:0] LEN_MARKED = 2'b00;
endpackage

// File: rtl/sdlc_char_fmt.sv
module sdlc_char_fmt #(
   parameter int DATA_W  = 8,
   parameter int MIN_LEN = 5,
   parameter int LEN_W   = 2,
   localparam int CNT_W  = $clog2(DATA_W + 2)
) (
   input  logic [DATA_W-1:0] raw,
   input  logic [LEN_W-1:0]  len_code,
   output logic [CNT_W-1:0]  nbits,
   output logic [DATA_W-1:0] payload
);
   import sdlc_ser_pkg::*;

   localparam int MARK_CAP = MIN_LEN - 1;

   if (MIN_LEN + (1 << LEN_W) - 1 != DATA_W) begin : g_len_check
      $error("sdlc_char_fmt: length codes must span MIN_LEN..DATA_W");
   end
   if (MIN_LEN < 2) begin : g_min_check
      $error("sdlc_char_fmt: MIN_LEN too small");
   end

   logic [CNT_W-1:0] lead;
   logic             stop;

   // count marker ones from the top bit down to the first zero
   always_comb begin
      lead = '0;
      stop = 1'b0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         if (!stop) begin
            if (raw[i] && (lead < CNT_W'(MARK_CAP))) lead = lead + 1'b1;
            else stop = 1'b1;
         end
      end
   end

   always_comb begin
      if (len_code == LEN_W'(LEN_MARKED))
         nbits = CNT_W'(MIN_LEN) - lead;
      else
         nbits = CNT_W'(MIN_LEN) + CNT_W'(len_code);
   end

   for (genvar g = 0; g < DATA_W; g++) begin : g_mask
      assign payload[g] = raw[g] & (CNT_W'(g) < nbits);
   end
endmodule

// File: rtl/sdlc_par_gen.sv
module sdlc_par_gen #(
   parameter int DATA_W = 8,
   parameter bit TREE   = 1'b1
) (
   input  logic [DATA_W-1:0] bits,
   input  logic              odd,
   output logic              par
);
   logic sum;

   if (TREE) begin : g_tree
      assign sum = ^bits;
   end else begin : g_ripple
      logic [DATA_W:0] chain;
      assign chain[0] = 1'b0;
      for (genvar g = 0; g < DATA_W; g++) begin : g_link
         assign chain[g+1] = chain[g] ^ bits[g];
      end
      assign sum = chain[DATA_W];
   end

   assign par = sum ^ odd;
endmodule

// File: rtl/sdlc_tx_serializer.sv
module sdlc_tx_serializer #(
   parameter int          DATA_W   = 8,
   parameter int          MIN_LEN  = 5,
   parameter int          LEN_W    = 2,
   parameter logic [7:0]  FLAG     = 8'h7E,
   parameter bit          PAR_TREE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [LEN_W-1:0]  len_code,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              idle_flag,
   output logic              txd,
   output logic              busy
);
   import sdlc_ser_pkg::*;

   localparam int SR_W    = DATA_W + 1;
   localparam int CNT_W   = $clog2(DATA_W + 2);
   localparam int GROUP_W = 8;

   if (DATA_W != GROUP_W) begin : g_width_check
      $error("sdlc_tx_serializer: idle group and character width must match");
   end

   logic [SR_W-1:0]   sreg;
   logic [CNT_W-1:0]  cnt;
   unit_e             unit;
   logic [CNT_W-1:0]  nbits;
   logic [DATA_W-1:0] payload;
   logic              par_bit;
   logic [SR_W-1:0]   char_frame;
   logic [SR_W-1:0]   idle_frame;
   logic              at_end;
   logic              take;

   sdlc_char_fmt #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_fmt (
      .raw      (tx_data),
      .len_code (len_code),
      .nbits    (nbits),
      .payload  (payload)
   );

   sdlc_par_gen #(.DATA_W(DATA_W), .TREE(PAR_TREE)) u_par (
      .bits (payload),
      .odd  (par_odd),
      .par  (par_bit)
   );

   // data bits, then optional parity, rest padded with mark
   for (genvar g = 0; g < SR_W; g++) begin : g_frame
      if (g < DATA_W) begin : g_data
         assign char_frame[g] = (CNT_W'(g) < nbits) ? payload[g] :
                                (CNT_W'(g) == nbits) ? (par_en ? par_bit : 1'b1) : 1'b1;
      end else begin : g_top
         assign char_frame[g] = (CNT_W'(g) == nbits) ? (par_en ? par_bit : 1'b1) : 1'b1;
      end
   end

   assign idle_frame = {1'b1, (idle_flag ? FLAG : 8'hFF)};
   assign at_end     = (cnt == CNT_W'(1));
   assign take       = bit_en && at_end && tx_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg <= '1;
         cnt  <= CNT_W'(1);
         unit <= UNIT_IDLE;
      end else if (bit_en) begin
         if (at_end) begin
            if (tx_valid) begin
               sreg <= char_frame;
               cnt  <= nbits + CNT_W'(par_en);
               unit <= UNIT_DATA;
            end else begin
               sreg <= idle_frame;
               cnt  <= CNT_W'(GROUP_W);
               unit <= UNIT_IDLE;
            end
         end else begin
            sreg <= {1'b1, sreg[SR_W-1:1]};
            cnt  <= cnt - 1'b1;
         end
      end
   end

   assign txd      = sreg[0];
   assign tx_ready = at_end;
   assign busy     = (unit == UNIT_DATA);

   // R2: line holds between bit enables
   p_txd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(txd));

   // R6: ready moves only on bit enables
   p_ready_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_ready));

   // R9: an accepted character makes the block busy
   p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> busy);

   // R7: no offer at a boundary starts an eight-bit idle unit
   p_idle_unit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && tx_ready && !tx_valid) |=> (!busy && !tx_ready));

   // R3: loaded unit length lies within one to DATA_W+1 bits
   p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (cnt >= CNT_W'(1) && cnt <= CNT_W'(SR_W)));
endmodule

// File: tb/sdlc_tx_serializer_bench.sv
module sdlc_tx_serializer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic [1:0] len_code = 2'b11;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       idle_flag = 1'b1;
   logic       txd;
   logic       busy;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam logic [7:0] FLAG_PAT = 8'h7E;

   always #10 clk = ~clk;

   sdlc_tx_serializer u_sdlc_tx_serializer (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .len_code(len_code),
      .par_en(par_en), .par_odd(par_odd), .idle_flag(idle_flag),
      .txd(txd), .busy(busy)
   );

   // scoreboard: expected bit, last-bit flag, requirement tag
   bit    q_bit[$];
   bit    q_last[$];
   string q_tag[$];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: compute expected bits from the requirements, push, then offer
   task automatic send(input logic [7:0] d, input logic [1:0] lc, input bit pe,
                       input bit po, input string tag);
      int n;
      int lead;
      int ones;
      @(posedge clk); #1;
      if (lc == 2'b00) begin
         lead = 0;
         for (int i = 7; i >= 0; i--) begin
            if (d[i] && lead < 4) lead++;
            else break;
         end
         n = 5 - lead;
      end else begin
         n = 5 + int'(lc);
      end
      ones = 0;
      for (int i = 0; i < n; i++) begin
         q_bit.push_back(d[i]);
         q_last.push_back(!pe && (i == n - 1));
         q_tag.push_back(tag);
         if (d[i]) ones++;
      end
      if (pe) begin
         q_bit.push_back(po ? ((ones % 2) == 0) : ((ones % 2) == 1));
         q_last.push_back(1'b1);
         q_tag.push_back("R5 parity");
      end
      tx_data  = d;
      len_code = lc;
      par_en   = pe;
      par_odd  = po;
      tx_valid = 1'b1;
      forever begin
         @(negedge clk);
         if (bit_en && tx_ready) break;
      end
      @(posedge clk); #1;
      tx_valid = 1'b0;
      tx_data  = 8'hXX === 8'hXX ? 8'h00 : 8'h00;
   endtask

   task automatic wait_periods(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         while (!bit_en) @(negedge clk);
      end
   endtask

   // bit-clock enable: one pulse every four clocks
   initial begin
      wait (rst_n);
      forever begin
         repeat (3) @(posedge clk);
         #1 bit_en = 1'b1;
         @(posedge clk);
         #1 bit_en = 1'b0;
      end
   end

   // monitor: sample each bit period just before the edge that ends it
   bit first_period = 1'b1;
   bit prev_mode;
   bit cur_mode;
   int idle_pos = 0;

   always @(negedge clk) begin
      if (rst_n && bit_en && !done) begin
         if (first_period) begin
            first_period = 1'b0;
         end else if (busy) begin
            idle_pos = 0;
            if (q_bit.size() == 0) begin
               check(1'b0, "R9 busy without character", 1, 0);
            end else begin
               bit    eb;
               bit    el;
               string et;
               eb = q_bit.pop_front();
               el = q_last.pop_front();
               et = q_tag.pop_front();
               check(txd == eb, {et, " R2 data bit"}, int'(txd), int'(eb));
               check(tx_ready == el, {et, " R6 ready on last bit"}, int'(tx_ready), int'(el));
            end
         end else begin
            bit eb;
            if (idle_pos == 0) cur_mode = prev_mode;
            eb = cur_mode ? FLAG_PAT[idle_pos] : 1'b1;
            check(txd == eb, cur_mode ? "R7 flag idle (R8 group hold)" : "R7 mark idle (R8 group hold)",
                  int'(txd), int'(eb));
            check(tx_ready == (idle_pos == 7), "R6 ready at idle group end",
                  int'(tx_ready), int'(idle_pos == 7));
            idle_pos = (idle_pos + 1) % 8;
         end
         prev_mode = idle_flag;
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(txd == 1'b1 && busy == 1'b0 && tx_ready == 1'b1, "R1 reset state",
            {txd, busy, tx_ready}, 3'b101);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check(txd == 1'b1 && busy == 1'b0 && tx_ready == 1'b1, "R1 state after release",
            {txd, busy, tx_ready}, 3'b101);

      idle_flag = 1'b1;
      wait_periods(20);

      // R3 eight-bit characters back to back, R6 no gap
      send(8'hA5, 2'b11, 1'b0, 1'b0, "R3 len8");
      send(8'h3C, 2'b11, 1'b0, 1'b0, "R3 len8 R6 back-to-back");
      // R3 upper bits ignored
      send(8'hFF, 2'b10, 1'b0, 1'b0, "R3 len7");
      send(8'hC1, 2'b01, 1'b0, 1'b0, "R3 len6");
      // R5 parity senses
      send(8'h01, 2'b11, 1'b1, 1'b1, "R5 odd len8");
      send(8'h03, 2'b11, 1'b1, 1'b0, "R5 even len8");
      send(8'h00, 2'b01, 1'b1, 1'b1, "R5 odd len6");
      // R4 marker depths
      send(8'h15, 2'b00, 1'b0, 1'b0, "R4 five bits");
      send(8'h8A, 2'b00, 1'b0, 1'b0, "R4 four bits");
      send(8'hC5, 2'b00, 1'b0, 1'b0, "R4 three bits");
      send(8'hE2, 2'b00, 1'b0, 1'b0, "R4 two bits");
      send(8'hF1, 2'b00, 1'b0, 1'b0, "R4 one bit");
      send(8'hFF, 2'b00, 1'b1, 1'b0, "R4 saturated marker");
      // R8 config changed while previous character is shifting
      send(8'h96, 2'b11, 1'b1, 1'b1, "R8 long unit");
      send(8'hE3, 2'b00, 1'b0, 1'b0, "R8 next short unit");
      wait_periods(12);

      // R7 mark idle, R8 switch mid group
      idle_flag = 1'b0;
      wait_periods(19);
      idle_flag = 1'b1;
      wait_periods(19);
      idle_flag = 1'b0;
      wait_periods(3);
      send(8'h5A, 2'b10, 1'b1, 1'b0, "R9 from mark idle");
      wait_periods(20);

      check(q_bit.size() == 0, "R9 all characters sent", q_bit.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule